// File: doc/BRIEF.md
# Test-Port Controller with Secure-Flash Lockout Recovery

This block is a chip-level test access port controller that keeps the usual test functions and adds one way out of a locked device. With flash security on, the debug path cannot read the flash. The ID register, the bypass register and the boundary cells stay reachable over the four-wire test port. A dedicated public instruction selects a 7-bit data register. The value shifted into it is the clock divider that the flash controller uses for a mass erase.

The erase is requested only after two things have happened, in this order: the divider register has been updated under the recovery instruction, and the controller has then entered Run-Test/Idle. The request stays up only while the controller remains in Run-Test/Idle. Leaving that state withdraws the request, and the flash side abandons the partial erase. When the flash side reports completion, the block raises a hold output. The whole array, configuration area included, has been wiped, which also clears the protection setting. The hold keeps the chip out of normal operation until the test port has passed through Test-Logic-Reset and the chip reset input has been asserted, in either order.

Under the recovery instruction, a capture of the data register loads a status word. A later data scan can therefore read whether the erase is busy and whether it has finished.

Top module: `lkr_tap_top`

## Requirements
- R1: After the TAP reset, or on any entry to Test-Logic-Reset, the current instruction is IDCODE, and a 32-bit data scan shifts out the identification value 0x1ABCD01D, least significant bit first.
- R2: The controller follows the standard 16-state TAP state graph, with TMS sampled on the rising TCK edge. Five TCK cycles with TMS high reach Test-Logic-Reset from any state, including the middle of an instruction shift.
- R3: Capture-IR loads the binary pattern 0001 into the 4-bit instruction shift register, and this pattern is what Shift-IR presents on TDO.
- R4: Opcode 0xF and every opcode that is not defined select a 1-bit bypass register that captures 0. Data on TDO therefore appears one TCK later than on TDI.
- R5: Opcodes 0x1 (sample) and 0x0 (drive) both select an 8-bit boundary register. Capture-DR loads `bsr_in`, and Update-DR copies the shifted value onto `bsr_out`.
- R6: Opcode 0x8 (lockout recovery) selects a 7-bit register. Update-DR under this opcode copies the shifted value onto `erase_div`, and `erase_div` changes at no other time.
- R7: `erase_req` is high only while opcode 0x8 is current, the 7-bit register has been updated since the last Test-Logic-Reset, and the TAP is in Run-Test/Idle. Entering Run-Test/Idle before that update requests nothing.
- R8: Leaving Run-Test/Idle drops `erase_req` on the same TCK edge. After a new divider update, returning to Run-Test/Idle raises `erase_req` again.
- R9: Capture-DR under opcode 0x8 loads the status word. Bit 0 is the `erase_busy` input, bit 1 is a sticky done flag, and bits 6 to 2 are zero. The done flag stays set until the hold of R11 is released.
- R10: When `erase_done` is seen high while `erase_req` is high, `recovery_hold` rises on that TCK edge. While it stays high, `erase_req` remains low.
- R11: `recovery_hold` falls only after both a visit to Test-Logic-Reset and an assertion of `chip_rst_n` have occurred since it rose, in either order. Neither of them alone releases it.
- R12: TDO is updated on falling TCK edges only. `tdo_oe` is high only for the TCK cycle that follows a Shift-IR or Shift-DR state and is low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low TAP reset |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO drive enable, high during shift states |
| chip_rst_n | input | 1 | External chip reset, active low, sampled on TCK |
| bsr_in | input | 8 | Pin values captured into the boundary register |
| bsr_out | output | 8 | Boundary update latch driven toward the pins |
| erase_req | output | 1 | Mass-erase request to the flash controller |
| erase_div | output | 7 | Erase clock divider value |
| erase_busy | input | 1 | Flash controller is erasing |
| erase_done | input | 1 | Flash controller finished the erase |
| recovery_hold | output | 1 | Keeps the chip out of normal operation after an erase |

## Verification
The bench builds the block with its default parameters: a 4-bit instruction register, a 7-bit divider register, an 8-bit boundary register and a 32-bit identification value. It runs a flash model that needs 20 uninterrupted request cycles to finish an erase. With 20 cycles, an abort after five Run-Test/Idle cycles and a completion within one wait window are both quick to reach. The short instruction register leaves several undefined opcodes to try against the bypass rule. Two separate recovery rounds use the two release orders of the hold, and each round reads the sticky status through a data scan.

// File: rtl/lkr_pkg.sv
// Shared types for the lockout recovery test port.
// Assumes: the state encoding is private to this block.
package lkr_pkg;

    typedef enum logic [3:0] {
        ST_TLR,     ST_RTI,
        ST_SEL_DR,  ST_CAP_DR,  ST_SHIFT_DR, ST_EXIT1_DR,
        ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
        ST_SEL_IR,  ST_CAP_IR,  ST_SHIFT_IR, ST_EXIT1_IR,
        ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDCODE,
        DR_BOUNDARY,
        DR_DIVIDER
    } dr_sel_t;

endpackage

// File: rtl/lkr_tap_fsm.sv
// 16-state test access port sequencer.
// Does: advances on rising TCK from TMS; trst_n forces Test-Logic-Reset.
// Assumes: trst_n is synchronous to TCK and active low.
module lkr_tap_fsm
    import lkr_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state function of the standard TAP graph.
    always_comb begin
        unique case (state)
            ST_TLR:      nxt = tms ? ST_TLR      : ST_RTI;
            ST_RTI:      nxt = tms ? ST_SEL_DR   : ST_RTI;
            ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_RTI;
            ST_SEL_IR:   nxt = tms ? ST_TLR      : ST_CAP_IR;
            ST_CAP_IR:   nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_RTI;
            default:     nxt = ST_TLR;
        endcase
    end

    // State register with synchronous TAP reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    // R2: the TAP reset always lands in Test-Logic-Reset.
    p_trst_to_tlr_r2: assert property (@(posedge tck)
        !trst_n |=> (state == ST_TLR));

    // R2: from Select-IR, TMS high leads straight to Test-Logic-Reset.
    p_selir_exit_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_SEL_IR && tms) |=> (state == ST_TLR));

endmodule

// File: rtl/lkr_ir.sv
// Instruction register and data-register selection.
// Does: captures the fixed pattern, shifts, updates, and loads IDCODE
// in Test-Logic-Reset; unknown opcodes fall back to bypass.
// Assumes: IR_LEN >= 2; opcodes are distinct.
module lkr_ir
    import lkr_pkg::*;
#(
    parameter int                IR_LEN     = 4,
    parameter logic [IR_LEN-1:0] OP_EXTEST  = 4'h0,
    parameter logic [IR_LEN-1:0] OP_SAMPLE  = 4'h1,
    parameter logic [IR_LEN-1:0] OP_IDCODE  = 4'h2,
    parameter logic [IR_LEN-1:0] OP_LOCKOUT = 4'h8
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_t state,
    input  logic       tdi,
    output logic       ir_lsb,
    output dr_sel_t    dr_sel
);

    localparam logic [IR_LEN-1:0] CAP_PAT = {{(IR_LEN-2){1'b0}}, 2'b01};

    logic [IR_LEN-1:0] ir_sr;
    logic [IR_LEN-1:0] ir_q;

    // Instruction shift path: capture pattern, then shift in from TDI.
    always_ff @(posedge tck) begin
        if (!trst_n)                    ir_sr <= '0;
        else if (state == ST_CAP_IR)    ir_sr <= CAP_PAT;
        else if (state == ST_SHIFT_IR)  ir_sr <= {tdi, ir_sr[IR_LEN-1:1]};
    end

    // Current instruction: IDCODE on reset, new opcode on Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n)                    ir_q <= OP_IDCODE;
        else if (state == ST_TLR)       ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR)    ir_q <= ir_sr;
    end

    // Decode the opcode into a data-register selection.
    always_comb begin
        if (ir_q == OP_IDCODE)                           dr_sel = DR_IDCODE;
        else if (ir_q == OP_EXTEST || ir_q == OP_SAMPLE) dr_sel = DR_BOUNDARY;
        else if (ir_q == OP_LOCKOUT)                     dr_sel = DR_DIVIDER;
        else                                             dr_sel = DR_BYPASS;
    end

    assign ir_lsb = ir_sr[0];

    // R1: any cycle in Test-Logic-Reset leaves IDCODE selected.
    p_tlr_idcode_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (dr_sel == DR_IDCODE));

endmodule

// File: rtl/lkr_recovery.sv
// Divider data register, erase request and post-erase hold.
// Does: arms on divider update, requests erase only in Run-Test/Idle,
// latches completion and holds the chip until both resets are seen.
// Assumes: erase_busy/erase_done are synchronous to TCK; the hold
// registers are cleared by chip reset together with Test-Logic-Reset.
module lkr_recovery
    import lkr_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             chip_rst_n,
    input  tap_state_t       state,
    input  logic             tdi,
    input  logic             div_sel,
    input  logic             erase_busy,
    input  logic             erase_done,
    output logic             div_lsb,
    output logic             erase_req,
    output logic [DIV_W-1:0] erase_div,
    output logic             recovery_hold
);

    logic [DIV_W-1:0] div_sr;
    logic [DIV_W-1:0] status_w;
    logic             armed;
    logic             done_st;
    logic             tlr_seen;
    logic             chip_seen;
    logic             in_tlr;
    logic             release_hold;
    logic             finish;

    assign in_tlr       = (state == ST_TLR);
    assign status_w     = {{(DIV_W-2){1'b0}}, done_st, erase_busy};
    assign erase_req    = armed && div_sel && (state == ST_RTI) && !recovery_hold;
    assign finish       = erase_req && erase_done;
    assign release_hold = (tlr_seen || in_tlr) && (chip_seen || !chip_rst_n);
    assign div_lsb      = div_sr[0];

    // Divider shift path: status on capture, TDI on shift.
    always_ff @(posedge tck) begin
        if (!trst_n)                                div_sr <= '0;
        else if (div_sel && state == ST_CAP_DR)     div_sr <= status_w;
        else if (div_sel && state == ST_SHIFT_DR)   div_sr <= {tdi, div_sr[DIV_W-1:1]};
    end

    // Divider latch and arming on Update-DR; disarm on reset or finish.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            erase_div <= '0;
            armed     <= 1'b0;
        end else if (in_tlr) begin
            armed     <= 1'b0;
        end else if (div_sel && state == ST_UPD_DR) begin
            erase_div <= div_sr;
            armed     <= 1'b1;
        end else if (finish) begin
            armed     <= 1'b0;
        end
    end

    // Post-erase hold: set on completion, released by both resets.
    always_ff @(posedge tck) begin
        if (release_hold) begin
            recovery_hold <= 1'b0;
            done_st       <= 1'b0;
            tlr_seen      <= 1'b0;
            chip_seen     <= 1'b0;
        end else if (finish) begin
            recovery_hold <= 1'b1;
            done_st       <= 1'b1;
        end else if (recovery_hold) begin
            if (in_tlr)      tlr_seen  <= 1'b1;
            if (!chip_rst_n) chip_seen <= 1'b1;
        end
    end

    // R7: a request exists only in Run-Test/Idle under the divider opcode.
    p_req_rti_only_r7: assert property (@(posedge tck) disable iff (!trst_n)
        erase_req |-> (state == ST_RTI && div_sel));

    // R6: the divider output moves only through a divider update.
    p_div_stable_r6: assert property (@(posedge tck) disable iff (!trst_n)
        !(div_sel && state == ST_UPD_DR) |=> $stable(erase_div));

    // R10: completion raises the hold on the next edge.
    p_done_sets_hold_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (erase_req && erase_done) |=> recovery_hold);

    // R10: no request while the hold is up.
    p_hold_blocks_req_r10: assert property (@(posedge tck) disable iff (!trst_n)
        recovery_hold |-> !erase_req);

    // R11: without a chip reset the hold cannot drop.
    p_hold_needs_chip_r11: assert property (@(posedge tck) disable iff (!trst_n)
        (recovery_hold && !chip_seen && chip_rst_n) |=> recovery_hold);

    // R11: without a Test-Logic-Reset visit the hold cannot drop.
    p_hold_needs_tlr_r11: assert property (@(posedge tck) disable iff (!trst_n)
        (recovery_hold && !tlr_seen && !in_tlr) |=> recovery_hold);

    // R9: the done flag persists for as long as the hold does.
    p_done_sticky_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (done_st && recovery_hold && !release_hold) |=> done_st);

endmodule

// File: rtl/lkr_tap_top.sv
// Test access port with IDCODE, bypass, boundary and lockout recovery.
// Does: muxes the selected data register to TDO on falling TCK and
// hosts the identification, bypass and boundary registers.
// Assumes: all logic runs on TCK; resets are synchronous and active low.
module lkr_tap_top
    import lkr_pkg::*;
#(
    parameter int                IR_LEN     = 4,
    parameter int                DIV_W      = 7,
    parameter int                BSR_LEN    = 8,
    parameter logic [31:0]       ID_VALUE   = 32'h1ABC_D01D,
    parameter logic [IR_LEN-1:0] OP_EXTEST  = 4'h0,
    parameter logic [IR_LEN-1:0] OP_SAMPLE  = 4'h1,
    parameter logic [IR_LEN-1:0] OP_IDCODE  = 4'h2,
    parameter logic [IR_LEN-1:0] OP_LOCKOUT = 4'h8
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic               chip_rst_n,
    input  logic [BSR_LEN-1:0] bsr_in,
    output logic [BSR_LEN-1:0] bsr_out,
    output logic               erase_req,
    output logic [DIV_W-1:0]   erase_div,
    input  logic               erase_busy,
    input  logic               erase_done,
    output logic               recovery_hold
);

    localparam int ID_W = 32;

    tap_state_t         state;
    dr_sel_t            dr_sel;
    logic               ir_lsb;
    logic               div_lsb;
    logic               dr_lsb;
    logic               bypass_q;
    logic [ID_W-1:0]    id_sr;
    logic [BSR_LEN-1:0] bsr_sr;
    logic               in_shift_dr;
    logic               in_shift_ir;

    assign in_shift_dr = (state == ST_SHIFT_DR);
    assign in_shift_ir = (state == ST_SHIFT_IR);

    lkr_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    lkr_ir #(
        .IR_LEN     (IR_LEN),
        .OP_EXTEST  (OP_EXTEST),
        .OP_SAMPLE  (OP_SAMPLE),
        .OP_IDCODE  (OP_IDCODE),
        .OP_LOCKOUT (OP_LOCKOUT)
    ) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .ir_lsb (ir_lsb),
        .dr_sel (dr_sel)
    );

    lkr_recovery #(
        .DIV_W (DIV_W)
    ) u_rec (
        .tck           (tck),
        .trst_n        (trst_n),
        .chip_rst_n    (chip_rst_n),
        .state         (state),
        .tdi           (tdi),
        .div_sel       (dr_sel == DR_DIVIDER),
        .erase_busy    (erase_busy),
        .erase_done    (erase_done),
        .div_lsb       (div_lsb),
        .erase_req     (erase_req),
        .erase_div     (erase_div),
        .recovery_hold (recovery_hold)
    );

    // Bypass cell: captures zero, then passes TDI through one stage.
    always_ff @(posedge tck) begin
        if (!trst_n)                                         bypass_q <= 1'b0;
        else if (dr_sel == DR_BYPASS && state == ST_CAP_DR)  bypass_q <= 1'b0;
        else if (dr_sel == DR_BYPASS && in_shift_dr)         bypass_q <= tdi;
    end

    // Identification register: loads the fixed value, then shifts.
    always_ff @(posedge tck) begin
        if (!trst_n)                                         id_sr <= '0;
        else if (dr_sel == DR_IDCODE && state == ST_CAP_DR)  id_sr <= ID_VALUE;
        else if (dr_sel == DR_IDCODE && in_shift_dr)         id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Boundary register: captures pins, shifts, updates the output latch.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            bsr_sr  <= '0;
            bsr_out <= '0;
        end else if (dr_sel == DR_BOUNDARY) begin
            if (state == ST_CAP_DR)     bsr_sr  <= bsr_in;
            else if (in_shift_dr)       bsr_sr  <= {tdi, bsr_sr[BSR_LEN-1:1]};
            else if (state == ST_UPD_DR) bsr_out <= bsr_sr;
        end
    end

    // Select the serial output of the active data register.
    always_comb begin
        unique case (dr_sel)
            DR_IDCODE:   dr_lsb = id_sr[0];
            DR_BOUNDARY: dr_lsb = bsr_sr[0];
            DR_DIVIDER:  dr_lsb = div_lsb;
            default:     dr_lsb = bypass_q;
        endcase
    end

    // TDO and its enable change on the falling TCK edge only.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= in_shift_dr || in_shift_ir;
            tdo    <= in_shift_ir ? ir_lsb : (in_shift_dr ? dr_lsb : 1'b0);
        end
    end

    // R12: outside the shift states the driver is released next cycle.
    p_oe_shift_only_r12: assert property (@(negedge tck) disable iff (!trst_n)
        !(in_shift_dr || in_shift_ir) |=> !tdo_oe);

    // R5: the boundary output latch moves only on a boundary update.
    p_bsr_update_r5: assert property (@(posedge tck) disable iff (!trst_n)
        !(dr_sel == DR_BOUNDARY && state == ST_UPD_DR) |=> $stable(bsr_out));

endmodule

// File: tb/lkr_tap_top_tb.sv
// Scoreboard bench: scan tasks queue expected words, a monitor compares.
module lkr_tap_top_tb;

    localparam int          IR_LEN    = 4;
    localparam int          DIV_W     = 7;
    localparam int          BSR_LEN   = 8;
    localparam logic [31:0] ID_VALUE  = 32'h1ABC_D01D;
    localparam int          ERASE_CYC = 20;

    logic               tck = 1'b0;
    logic               trst_n, tms, tdi, chip_rst_n;
    logic               tdo, tdo_oe;
    logic [BSR_LEN-1:0] bsr_in, bsr_out;
    logic               erase_req, erase_busy, erase_done, recovery_hold;
    logic [DIV_W-1:0]   erase_div;

    int          n_chk = 0, n_fail = 0;
    logic        tdo_bit;
    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];
    int          f_cnt = 0, abort_cnt = 0, done_cnt = 0;
    logic [DIV_W-1:0] div_at_req = '0;
    bit          done_flag = 0;

    always #5 tck = ~tck;

    lkr_tap_top u_dut (
        .tck (tck), .trst_n (trst_n), .tms (tms), .tdi (tdi),
        .tdo (tdo), .tdo_oe (tdo_oe), .chip_rst_n (chip_rst_n),
        .bsr_in (bsr_in), .bsr_out (bsr_out),
        .erase_req (erase_req), .erase_div (erase_div),
        .erase_busy (erase_busy), .erase_done (erase_done),
        .recovery_hold (recovery_hold)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_word(input string tag, input logic [31:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // One TCK cycle: drive, note TDO before the rising edge, settle.
    task automatic tick(input logic m, input logic d);
        tms = m; tdi = d; tdo_bit = tdo;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic shift_bits(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i]);
            dout[i] = tdo_bit;
        end
    endtask

    // From Run-Test/Idle: data scan, back to Run-Test/Idle.
    task automatic dr_scan(input int n, input logic [31:0] din);
        logic [31:0] o;
        tick(1, 0); tick(0, 0); tick(0, 0);
        shift_bits(n, din, o);
        tick(1, 0); tick(0, 0);
        act_q.push_back(o);
    endtask

    // From Run-Test/Idle: instruction scan, back to Run-Test/Idle.
    task automatic ir_scan(input logic [IR_LEN-1:0] op);
        logic [31:0] o;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        shift_bits(IR_LEN, 32'(op), o);
        tick(1, 0); tick(0, 0);
        act_q.push_back(o);
    endtask

    task automatic tlr_by_tms();
        for (int i = 0; i < 5; i++) tick(1, 0);
    endtask

    // Monitor: pops actual and expected words as scans complete.
    initial begin
        forever begin
            wait (act_q.size() != 0);
            check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
        end
    end

    // Flash model: needs ERASE_CYC uninterrupted request cycles.
    initial begin
        erase_busy = 1'b0; erase_done = 1'b0;
        forever begin
            @(negedge tck);
            if (erase_req) begin
                f_cnt++;
                if (f_cnt == 1) div_at_req = erase_div;
                erase_busy = 1'b1;
                erase_done = (f_cnt == ERASE_CYC);
                if (erase_done) done_cnt++;
            end else begin
                if (erase_busy && !erase_done) abort_cnt++;
                erase_busy = 1'b0; erase_done = 1'b0; f_cnt = 0;
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge tck);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        trst_n = 0; chip_rst_n = 0; tms = 1; tdi = 0; bsr_in = '0;
        repeat (5) @(negedge tck);
        #1; trst_n = 1; chip_rst_n = 1;

        check("R12 oe low after reset", 32'(tdo_oe), 0);
        check("R7 no request after reset", 32'(erase_req), 0);
        check("R11 hold low after reset", 32'(recovery_hold), 0);
        tick(0, 0);

        expect_word("R1 idcode after reset", ID_VALUE);
        dr_scan(32, 32'h0);

        // R12: TDO holds across the rising edge, moves on the falling edge.
        tick(1, 0); tick(0, 0); tick(0, 0);
        check("R12 oe in shift", 32'(tdo_oe), 1);
        check("R12 first id bit", 32'(tdo), 32'(ID_VALUE[0]));
        tms = 0; tdi = 0;
        @(posedge tck); #1;
        check("R12 stable after rise", 32'(tdo), 32'(ID_VALUE[0]));
        @(negedge tck); #1;
        check("R12 updated after fall", 32'(tdo), 32'(ID_VALUE[1]));
        tlr_by_tms(); tick(0, 0);
        check("R12 oe low in idle", 32'(tdo_oe), 0);

        expect_word("R3 capture pattern", 32'h1);
        ir_scan(4'hF);
        expect_word("R4 bypass delay", {24'h0, 8'hC5 << 1});
        dr_scan(8, 32'hC5);
        expect_word("R3 capture pattern again", 32'h1);
        ir_scan(4'h5);
        expect_word("R4 undefined opcode bypass", {24'h0, 8'h3A << 1});
        dr_scan(8, 32'h3A);

        // R2: abandon an instruction shift with five TMS-high cycles.
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
        tlr_by_tms(); tick(0, 0);
        expect_word("R2 reset mid-shift gives idcode", ID_VALUE);
        dr_scan(32, 32'h0);

        expect_word("R3 before sample", 32'h1);
        ir_scan(4'h1);
        bsr_in = 8'hA5;
        expect_word("R5 sample captures pins", 32'hA5);
        dr_scan(8, 32'h3C);
        check("R5 sample updates latch", 32'(bsr_out), 32'h3C);
        expect_word("R3 before drive", 32'h1);
        ir_scan(4'h0);
        expect_word("R5 drive captures pins", 32'hA5);
        dr_scan(8, 32'h96);
        check("R5 drive updates latch", 32'(bsr_out), 32'h96);

        expect_word("R3 before lockout", 32'h1);
        ir_scan(4'h8);
        check("R7 idle before divider update", 32'(erase_req), 0);
        expect_word("R9 idle status", 32'h0);
        dr_scan(7, 32'h2B);
        check("R7 request in idle after update", 32'(erase_req), 1);
        check("R6 divider output", 32'(erase_div), 32'h2B);

        repeat (5) tick(0, 0);
        expect_word("R9 status after abort", 32'h0);
        dr_scan(7, 32'h2B);
        check("R8 early exit aborted erase", abort_cnt, 1);
        check("R8 request resumes in idle", 32'(erase_req), 1);
        check("R10 no hold after abort", 32'(recovery_hold), 0);

        repeat (30) tick(0, 0);
        check("R10 hold after completion", 32'(recovery_hold), 1);
        check("R10 request low under hold", 32'(erase_req), 0);
        check("R10 one completion", done_cnt, 1);
        check("R6 divider seen by flash", 32'(div_at_req), 32'h2B);
        expect_word("R9 sticky done status", 32'h2);
        dr_scan(7, 32'h11);
        check("R10 idle stays quiet under hold", 32'(erase_req), 0);

        tlr_by_tms(); tick(1, 0);
        check("R11 reset state alone keeps hold", 32'(recovery_hold), 1);
        chip_rst_n = 0; tick(1, 0); tick(1, 0); chip_rst_n = 1;
        check("R11 both resets release hold", 32'(recovery_hold), 0);

        tick(0, 0);
        expect_word("R3 second round", 32'h1);
        ir_scan(4'h8);
        expect_word("R9 done cleared after release", 32'h0);
        dr_scan(7, 32'h05);
        check("R6 second divider", 32'(erase_div), 32'h05);
        repeat (30) tick(0, 0);
        check("R10 second completion hold", 32'(recovery_hold), 1);
        chip_rst_n = 0; tick(0, 0); tick(0, 0); chip_rst_n = 1; tick(0, 0);
        check("R11 chip reset alone keeps hold", 32'(recovery_hold), 1);
        tlr_by_tms(); tick(1, 0);
        check("R11 reset state after chip reset releases", 32'(recovery_hold), 0);

        wait (act_q.size() == 0);
        #1;
        finish_run();
    end

endmodule